// File: doc/BRIEF.md
# Interrupt Controller Command Word Decoder

This block is the host-facing register front end of an eight-input interrupt controller. A host reaches it through a one-bit address, a byte of write data, a byte of read data and separate read and write strobes. It walks the initialization word sequence, decodes the operation commands that end interrupts or move the rotating priority, and picks which register a read returns. It does not resolve priority itself. It holds the control fields that the priority resolver consumes: mask, vector base, automatic end-of-interrupt, rotate-in-automatic mode, special mask, special fully nested mode, read select and poll. It also holds the in-service register and the priority offset that the end-of-interrupt and rotate commands change.

The first initialization word goes to address 0 with bit 4 set. The words that follow go to address 1. Two flags latched from the first word decide whether the cascade word and the mode word are expected or skipped. Once the sequence has finished, address 1 writes load the mask. Address 0 writes with bit 4 clear are operation commands: bit 3 set selects the read/poll/special-mask command and bit 3 clear selects the end-of-interrupt/rotate command. The resolver sets in-service bits through an acknowledge input, and it reads back the offset and a re-evaluate strobe.

Top module: `intc_cmd_decoder`

## Requirements
- R1: An address 0 write with bit 4 set clears mask, in-service register, priority offset, poll, read select (to the request register), special mask, automatic EOI, rotate-in-automatic mode and special fully nested mode. It keeps the vector base, latches single mode from bit 1 and the mode-word-needed flag from bit 0, and makes the next address 1 write the vector-base word.
- R2: If bit 3 of that first word (the level-trigger request) is set, `level_unsup_o` pulses high for exactly the one cycle after the write.
- R3: The vector-base word stores data with bits 2:0 forced to zero. It is followed by the cascade word unless single mode is set. Otherwise it is followed by the mode word if that word is needed, or else the sequence ends. After the cascade word, the mode word follows if it is needed, or else the sequence ends.
- R4: The mode word sets special fully nested mode from bit 4 and automatic EOI from bit 1, and ends the sequence.
- R5: When no sequence is in progress, an address 1 write loads the mask, and an address 1 read returns the mask.
- R6: An address 0 write with bits 4 and 3 equal to 0 and 1 sets poll from bit 2. When bit 1 is set, it sets read select from bit 0 (1 = in-service, 0 = request). When bit 6 is set, it sets special mask from bit 5. A field whose enable bit is clear keeps its value.
- R7: An address 0 write with bits 4 and 3 both clear is a command with code in bits 7:5. Code 0 clears rotate-in-automatic mode, code 4 sets it, and code 2 changes no state.
- R8: Code 1 clears the highest-priority in-service bit, where priority order is bit (offset+k) mod 8 for k = 0..7. Code 5 does the same and also sets the offset to that bit's index + 1 mod 8. With no in-service bit set, neither command changes anything.
- R9: Code 3 clears in-service bit data[2:0]. Code 6 sets the offset to (data[2:0]+1) mod 8. Code 7 does both.
- R10: An address 0 read returns the poll input while poll is set, otherwise the in-service register if read select is 1, or the request input if it is 0. Any address 0 read clears poll.
- R11: `reeval_o` is high for the one cycle after every command with code 1, 3, 5, 6 or 7, and low otherwise.
- R12: Each cycle, the bits of `isr_set_i` are ORed into the in-service register after that cycle's command clears are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irr_i | input | 8 | Request register from the resolver |
| poll_vec_i | input | 8 | Poll word from the resolver |
| isr_set_i | input | 8 | In-service bits to set on acknowledge |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base |
| aeoi_o | output | 1 | Automatic end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic EOI |
| smm_o | output | 1 | Special mask mode |
| sfnm_o | output | 1 | Special fully nested mode |
| rd_isr_o | output | 1 | Read select: 1 = in-service |
| poll_o | output | 1 | Poll mode pending |
| isr_o | output | 8 | In-service register |
| prio_off_o | output | 3 | Priority offset (lowest-numbered priority slot) |
| reeval_o | output | 1 | Re-evaluate strobe |
| level_unsup_o | output | 1 | Unsupported level-trigger request pulse |

## Verification
Assertions check on every cycle the properties that hold locally in time. The first word resets the mask and the sequence state. The unsupported-mode pulse and the re-evaluate strobe appear only after their causing writes. Single mode never enters the cascade state. Poll drops after an address 0 read, and a specific EOI clears its named bit. The bench scenarios are needed for properties that span several operations. These are the four sequence-skip paths, identified by which later address 1 write lands in the mask. They also cover the rotating priority order when a non-specific EOI picks its bit under different offsets, the read multiplexer under every select combination, and the interplay of acknowledge sets with command clears during long random runs.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_st_e;

  typedef enum logic [2:0] {
    OP_ROT_AUTO_CLR = 3'd0,
    OP_EOI_ANY      = 3'd1,
    OP_NOP          = 3'd2,
    OP_EOI_ONE      = 3'd3,
    OP_ROT_AUTO_SET = 3'd4,
    OP_EOI_ANY_ROT  = 3'd5,
    OP_SET_OFFSET   = 3'd6,
    OP_EOI_ONE_ROT  = 3'd7
  } op_code_e;
endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_cmd_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              icw_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              aeoi_o,
  output logic              sfnm_o,
  output logic              level_unsup_o
);
  seq_st_e           state_q;
  logic              single_q, need4_q;
  logic [N_IRQ-1:0]  mask_q;
  logic [DATA_W-1:0] base_q;
  logic              aeoi_q, sfnm_q, unsup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      mask_q   <= '0;
      base_q   <= '0;
      aeoi_q   <= 1'b0;
      sfnm_q   <= 1'b0;
      unsup_q  <= 1'b0;
    end else begin
      unsup_q <= 1'b0;
      if (init_i) begin
        state_q  <= SEQ_BASE;
        single_q <= wdata_i[1];
        need4_q  <= wdata_i[0];
        mask_q   <= '0;
        aeoi_q   <= 1'b0;
        sfnm_q   <= 1'b0;
        unsup_q  <= wdata_i[3];
      end else if (icw_wr_i) begin
        unique case (state_q)
          SEQ_IDLE: mask_q <= wdata_i[N_IRQ-1:0];
          SEQ_BASE: begin
            base_q <= {wdata_i[DATA_W-1:IDX_W], {IDX_W{1'b0}}};
            if (!single_q)    state_q <= SEQ_CASC;
            else if (need4_q) state_q <= SEQ_MODE;
            else              state_q <= SEQ_IDLE;
          end
          SEQ_CASC: state_q <= need4_q ? SEQ_MODE : SEQ_IDLE;
          SEQ_MODE: begin
            sfnm_q  <= wdata_i[4];
            aeoi_q  <= wdata_i[1];
            state_q <= SEQ_IDLE;
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign mask_o        = mask_q;
  assign vec_base_o    = base_q;
  assign aeoi_o        = aeoi_q;
  assign sfnm_o        = sfnm_q;
  assign level_unsup_o = unsup_q;

  AST_INIT_CLEARS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (mask_q == '0 && state_q == SEQ_BASE && !aeoi_q && !sfnm_q)); // R1
  AST_UNSUP_FROM_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_q |-> $past(init_i)); // R2
  AST_SINGLE_NO_CASC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_q |-> state_q != SEQ_CASC); // R3
endmodule

// File: rtl/intc_op_ctrl.sv
module intc_op_ctrl
  import intc_cmd_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              op_wr_i,
  input  logic              rd0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_IRQ-1:0]  isr_set_i,
  output logic [N_IRQ-1:0]  isr_o,
  output logic [IDX_W-1:0]  prio_off_o,
  output logic              rot_aeoi_o,
  output logic              poll_o,
  output logic              rd_isr_o,
  output logic              smm_o,
  output logic              reeval_o
);
  logic [N_IRQ-1:0] isr_q, isr_clr;
  logic [IDX_W-1:0] off_q, off_d, top_idx, arg_idx;
  logic             top_found, rot_q, poll_q, rdsel_q, smm_q, reeval_q, reeval_d, rot_d;
  logic             ocw2_wr, ocw3_wr;
  op_code_e         code;

  assign ocw2_wr = op_wr_i && !wdata_i[3];
  assign ocw3_wr = op_wr_i &&  wdata_i[3];
  assign code    = op_code_e'(wdata_i[7:5]);
  assign arg_idx = wdata_i[IDX_W-1:0];

  // highest-priority in-service bit: scan from lowest rank upward, last hit wins
  always_comb begin
    top_found = 1'b0;
    top_idx   = '0;
    for (int k = N_IRQ - 1; k >= 0; k--) begin
      if (isr_q[IDX_W'(off_q + IDX_W'(k))]) begin
        top_found = 1'b1;
        top_idx   = IDX_W'(off_q + IDX_W'(k));
      end
    end
  end

  always_comb begin
    isr_clr  = '0;
    off_d    = off_q;
    rot_d    = rot_q;
    reeval_d = 1'b0;
    if (ocw2_wr) begin
      unique case (code)
        OP_ROT_AUTO_CLR: rot_d = 1'b0;
        OP_ROT_AUTO_SET: rot_d = 1'b1;
        OP_EOI_ANY, OP_EOI_ANY_ROT: begin
          reeval_d = 1'b1;
          if (top_found) begin
            isr_clr[top_idx] = 1'b1;
            if (code == OP_EOI_ANY_ROT) off_d = top_idx + 1'b1;
          end
        end
        OP_EOI_ONE: begin
          reeval_d         = 1'b1;
          isr_clr[arg_idx] = 1'b1;
        end
        OP_SET_OFFSET: begin
          reeval_d = 1'b1;
          off_d    = arg_idx + 1'b1;
        end
        OP_EOI_ONE_ROT: begin
          reeval_d         = 1'b1;
          isr_clr[arg_idx] = 1'b1;
          off_d            = arg_idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      off_q    <= '0;
      rot_q    <= 1'b0;
      poll_q   <= 1'b0;
      rdsel_q  <= 1'b0;
      smm_q    <= 1'b0;
      reeval_q <= 1'b0;
    end else if (init_i) begin
      isr_q    <= '0;
      off_q    <= '0;
      rot_q    <= 1'b0;
      poll_q   <= 1'b0;
      rdsel_q  <= 1'b0;
      smm_q    <= 1'b0;
      reeval_q <= 1'b0;
    end else begin
      isr_q    <= (isr_q & ~isr_clr) | isr_set_i;
      off_q    <= off_d;
      rot_q    <= rot_d;
      reeval_q <= reeval_d;
      if (ocw3_wr) begin
        poll_q <= wdata_i[2];
        if (wdata_i[1]) rdsel_q <= wdata_i[0];
        if (wdata_i[6]) smm_q   <= wdata_i[5];
      end else if (rd0_i) begin
        poll_q <= 1'b0;
      end
    end
  end

  assign isr_o      = isr_q;
  assign prio_off_o = off_q;
  assign rot_aeoi_o = rot_q;
  assign poll_o     = poll_q;
  assign rd_isr_o   = rdsel_q;
  assign smm_o      = smm_q;
  assign reeval_o   = reeval_q;

  AST_SPEC_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw2_wr && wdata_i[7:5] == 3'd3 && isr_set_i == '0) |=> !isr_q[$past(arg_idx)]); // R9
  AST_REEVAL_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reeval_q |-> $past(ocw2_wr)); // R11
  AST_POLL_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_i && poll_q && !op_wr_i && !init_i) |=> !poll_q); // R10
  AST_ROT_CODE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw2_wr && wdata_i[7:5] == 3'd4) |=> rot_q); // R7
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
  import intc_cmd_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_IRQ-1:0]  irr_i,
  input  logic [DATA_W-1:0] poll_vec_i,
  input  logic [N_IRQ-1:0]  isr_set_i,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              aeoi_o,
  output logic              rot_aeoi_o,
  output logic              smm_o,
  output logic              sfnm_o,
  output logic              rd_isr_o,
  output logic              poll_o,
  output logic [N_IRQ-1:0]  isr_o,
  output logic [IDX_W-1:0]  prio_off_o,
  output logic              reeval_o,
  output logic              level_unsup_o
);
  logic init_w, op_wr_w, icw_wr_w, rd0_w;

  assign init_w   = wr_i && !addr_i &&  wdata_i[4];
  assign op_wr_w  = wr_i && !addr_i && !wdata_i[4];
  assign icw_wr_w = wr_i &&  addr_i;
  assign rd0_w    = rd_i && !addr_i;

  intc_init_seq #(.N_IRQ(N_IRQ)) u_init_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .init_i        (init_w),
    .icw_wr_i      (icw_wr_w),
    .wdata_i       (wdata_i),
    .mask_o        (mask_o),
    .vec_base_o    (vec_base_o),
    .aeoi_o        (aeoi_o),
    .sfnm_o        (sfnm_o),
    .level_unsup_o (level_unsup_o)
  );

  intc_op_ctrl #(.N_IRQ(N_IRQ)) u_op_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_w),
    .op_wr_i    (op_wr_w),
    .rd0_i      (rd0_w),
    .wdata_i    (wdata_i),
    .isr_set_i  (isr_set_i),
    .isr_o      (isr_o),
    .prio_off_o (prio_off_o),
    .rot_aeoi_o (rot_aeoi_o),
    .poll_o     (poll_o),
    .rd_isr_o   (rd_isr_o),
    .smm_o      (smm_o),
    .reeval_o   (reeval_o)
  );

  always_comb begin
    if (addr_i)        rdata_o = DATA_W'(mask_o);
    else if (poll_o)   rdata_o = poll_vec_i;
    else if (rd_isr_o) rdata_o = DATA_W'(isr_o);
    else               rdata_o = DATA_W'(irr_i);
  end
endmodule

// File: tb/intc_cmd_decoder_bench.sv
module intc_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 0, rd = 0, addr = 0;
  logic [7:0] wdata = 0, rdata, irr = 0, pvec = 0, iset = 0;
  logic [7:0] mask, vbase, isr;
  logic [2:0] off;
  logic       aeoi, rota, smm, sfnm, rdsel, poll, reeval, unsup;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model
  logic [7:0] m_mask, m_base, m_isr;
  logic [2:0] m_off;
  logic       m_aeoi, m_rot, m_smm, m_sfnm, m_rdsel, m_poll, m_reeval, m_unsup, m_single, m_need4;
  int         m_st;

  intc_cmd_decoder u_intc_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irr_i(irr), .poll_vec_i(pvec), .isr_set_i(iset), .mask_o(mask),
    .vec_base_o(vbase), .aeoi_o(aeoi), .rot_aeoi_o(rota), .smm_o(smm), .sfnm_o(sfnm),
    .rd_isr_o(rdsel), .poll_o(poll), .isr_o(isr), .prio_off_o(off), .reeval_o(reeval),
    .level_unsup_o(unsup));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all();
    chk("R5", "mask", mask, m_mask);
    chk("R3", "vec_base", vbase, m_base);
    chk("R4", "aeoi", aeoi, m_aeoi);
    chk("R4", "sfnm", sfnm, m_sfnm);
    chk("R7", "rot_aeoi", rota, m_rot);
    chk("R6", "smm", smm, m_smm);
    chk("R6", "rd_isr", rdsel, m_rdsel);
    chk("R6", "poll", poll, m_poll);
    chk("R8", "isr", isr, m_isr);
    chk("R9", "offset", off, m_off);
    chk("R11", "reeval", reeval, m_reeval);
    chk("R2", "level_unsup", unsup, m_unsup);
    m_reeval = 0;
    m_unsup  = 0;
  endtask

  function automatic int top_isr();
    for (int k = 0; k < 8; k++)
      if (m_isr[(m_off + k) % 8]) return (m_off + k) % 8;
    return -1;
  endfunction

  function automatic void model_reset();
    m_mask = 0; m_base = 0; m_isr = 0; m_off = 0; m_aeoi = 0; m_rot = 0; m_smm = 0;
    m_sfnm = 0; m_rdsel = 0; m_poll = 0; m_reeval = 0; m_unsup = 0; m_single = 0;
    m_need4 = 0; m_st = 0;
  endfunction

  function automatic void model_write(logic a, logic [7:0] d);
    int t;
    if (!a && d[4]) begin
      m_mask = 0; m_isr = 0; m_off = 0; m_poll = 0; m_rdsel = 0; m_smm = 0;
      m_aeoi = 0; m_rot = 0; m_sfnm = 0;
      m_single = d[1]; m_need4 = d[0]; m_st = 1; m_unsup = d[3];
    end else if (!a && d[3]) begin
      m_poll = d[2];
      if (d[1]) m_rdsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (!a) begin
      case (d[7:5])
        3'd0: m_rot = 0;
        3'd4: m_rot = 1;
        3'd1, 3'd5: begin
          m_reeval = 1;
          t = top_isr();
          if (t >= 0) begin
            m_isr[t] = 0;
            if (d[7:5] == 3'd5) m_off = 3'((t + 1) % 8);
          end
        end
        3'd3: begin m_reeval = 1; m_isr[d[2:0]] = 0; end
        3'd6: begin m_reeval = 1; m_off = d[2:0] + 3'd1; end
        3'd7: begin m_reeval = 1; m_isr[d[2:0]] = 0; m_off = d[2:0] + 3'd1; end
        default: ;
      endcase
    end else begin
      case (m_st)
        0: m_mask = d;
        1: begin m_base = d & 8'hF8; m_st = !m_single ? 2 : (m_need4 ? 3 : 0); end
        2: m_st = m_need4 ? 3 : 0;
        default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_st = 0; end
      endcase
    end
  endfunction

  // caller is at a negedge
  task automatic do_wr(logic a, logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
    model_write(a, d);
    chk_all();
  endtask

  task automatic do_ack(logic [7:0] bits);
    iset = bits;
    @(negedge clk);
    iset = 0;
    m_isr |= bits;
    chk_all();
  endtask

  task automatic do_rd(logic a);
    logic [7:0] e;
    rd = 1; addr = a;
    #1;
    if (a) e = m_mask;
    else if (m_poll) e = pvec;
    else if (m_rdsel) e = m_isr;
    else e = irr;
    chk("R10", a ? "rdata_mask(R5)" : "rdata0", rdata, e);
    @(negedge clk);
    rd = 0;
    if (!a) m_poll = 0;
    chk_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    model_reset();
    irr = 8'h5A; pvec = 8'h83;
    repeat (3) @(negedge clk);
    chk_all(); // reset state, R1
    rst_n = 1;
    @(negedge clk);

    // R3/R4: single, mode word needed
    do_wr(0, 8'h1B);                // level bit set too: R2
    do_wr(1, 8'h47);                // base -> 0x40
    do_wr(1, 8'h12);                // mode: sfnm, aeoi
    do_wr(1, 8'hA5);                // mask R5
    do_rd(1);
    // R3: single, no mode word
    do_wr(0, 8'h12);
    do_wr(1, 8'h68);
    do_wr(1, 8'h3C);                // lands in mask
    // R3: cascade, no mode word
    do_wr(0, 8'h10);
    do_wr(1, 8'h20);
    do_wr(1, 8'h04);                // cascade word
    do_wr(1, 8'hC3);                // mask
    // R3: cascade + mode word
    do_wr(0, 8'h11);
    do_wr(1, 8'h88);
    do_wr(1, 8'h02);
    do_wr(1, 8'h10);
    do_wr(1, 8'h0F);

    // R12 + R8: non-specific EOI under offset 0 then rotated
    do_ack(8'h91);
    do_wr(0, 8'h20);                // code1 -> clears bit0
    do_wr(0, 8'hC2);                // code6 off=3 R9
    do_wr(0, 8'hA0);                // code5 -> clears bit4, off=5
    do_wr(0, 8'h20);                // clears bit7
    do_wr(0, 8'h20);                // empty: no change R8
    do_ack(8'h0C);
    do_wr(0, 8'h63);                // code3 bit3 R9
    do_wr(0, 8'hE2);                // code7 bit2, off=3
    do_wr(0, 8'hE7);                // code7 wrap off=0
    do_wr(0, 8'h80);                // code4 R7
    do_wr(0, 8'h40);                // code2 no-op
    do_wr(0, 8'h00);                // code0
    // R6/R10 reads
    do_wr(0, 8'h0B);                // read isr
    do_ack(8'h42);
    do_rd(0);
    do_wr(0, 8'h0C);                // poll
    do_rd(0);
    do_rd(0);                       // poll cleared
    do_wr(0, 8'h68);                // smm set
    do_wr(0, 8'h0A);                // read irr
    do_rd(0);

    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      irr  = 8'($urandom);
      pvec = 8'($urandom);
      case (sel)
        0: do_wr(0, {3'($urandom), 1'b1, 4'($urandom)});
        1, 2: do_wr(0, {3'($urandom), 2'b00, 3'($urandom)});
        3: do_wr(0, {1'b0, 2'($urandom), 2'b01, 3'($urandom)});
        4, 5: do_wr(1, 8'($urandom));
        6, 7: do_ack(8'($urandom) & 8'($urandom));
        8: do_rd(0);
        default: do_rd(1);
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule